// File: doc/BRIEF.md
# Command Stream Header Decoder

This block sits behind a command fetch unit and consumes a stream of 32-bit command dwords, one dword per cycle in which `in_valid` and `in_ready` are both high. The first dword of every command is a header. The decoder reports each header's client class, which is held in the top three bits. It carries out three memory-interface commands: a no-op, a register load of N address/value pairs, and end-of-batch. Every other command is stepped over by counting the payload dwords that its length field announces.

Each address/value pair of a register load comes out as a single-cycle write strobe. The strobe carries a word-aligned address, the value, and the address-space flag taken from the load header. A malformed register-load header sets a sticky error flag, and the command is then skipped. End-of-batch stops the decoder cleanly. It holds `in_ready` low until a restart pulse arrives, so no dword is lost and no dword is consumed past the end of the batch.

Top module: `cmd_stream_decoder`

## Requirements
- R1: For every accepted header, `hdr_valid` pulses for one cycle in the cycle after acceptance. `hdr_client` then carries header bits 31:29, where 0 is memory-interface, 2 is blitter and 3 is render. `hdr_global` carries header bit 22 when the client is 0, and 0 for any other client.
- R2: A memory-interface header (client 0) holds its opcode in bits 28:23. Any opcode below 0x10 other than 0x0A is a one-dword command. This covers the no-op 0x00, and the next accepted dword is treated as a header.
- R3: A memory-interface header whose opcode is 0x10 or above, other than 0x22, is followed by (bits 7:0)+1 payload dwords. These are consumed without any write, and the dword after them is a header.
- R4: A header of any client other than 0 is followed by (bits 7:0)+1 payload dwords. These are consumed without any write.
- R5: A header with opcode 0x22 and an odd length field L no larger than 251 loads N=(L+1)/2 pairs. The address dword of a pair comes first, then its value dword. For each pair, `wr_valid` pulses in the cycle after the value dword is accepted. `wr_addr` equals the address dword with bits 1:0 cleared, and `wr_data` equals the value dword.
- R6: `wr_global` on every write of a register load equals bit 22 of that load's header.
- R7: A header with opcode 0x22 and either an even length field L or L above 251 sets `load_err`, which stays high until reset. The L+1 dwords that follow are consumed with no write.
- R8: After the header with opcode 0x0A is accepted, `in_ready` is low from the next cycle on, and no dword is accepted while it is low. A `restart` pulse while stopped raises `in_ready` in the following cycle, and the next accepted dword is a header.
- R9: A `restart` pulse while the decoder is not stopped has no effect: `in_ready` stays high and the command being decoded continues.
- R10: During and right after reset, `in_ready` is 1 and `hdr_valid`, `wr_valid` and `load_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A command dword is offered |
| in_ready | output | 1 | The decoder takes a dword this cycle |
| in_data | input | 32 | Command dword |
| restart | input | 1 | Resume pulse after end-of-batch |
| hdr_valid | output | 1 | A header was accepted in the previous cycle |
| hdr_client | output | 3 | Client class of that header |
| hdr_global | output | 1 | Address-space bit of a memory-interface header |
| wr_valid | output | 1 | Register write strobe |
| wr_addr | output | 32 | Word-aligned register address |
| wr_data | output | 32 | Register value |
| wr_global | output | 1 | Address-space bit of the load that issued the write |
| load_err | output | 1 | Sticky malformed register-load flag |

## Verification
The assertions take for granted that `in_data` holds a legal stream, in which every header announces exactly the payload that follows it. They also assume that `restart` and `in_valid` are driven only from reset onward. The stimulus builds every command from its header fields, with payload counts that match those fields. It keeps `in_valid` high while the decoder is stopped, but only presents junk there, so a wrongly accepted dword would show up as a spurious header. Restart pulses are placed both while stopped and in the middle of a register load. The length corners are covered: a single pair, the full 126 pairs, an even length, and a length past the limit.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
   localparam int CMD_W       = 32;
   localparam int CLIENT_LO   = 29;
   localparam int OPC_LO      = 23;
   localparam int OPC_W       = 6;
   localparam int SPACE_BIT   = 22;

   localparam logic [2:0]       CLI_MEMIF = 3'd0;
   localparam logic [OPC_W-1:0] OPC_STOP  = 6'h0A;
   localparam logic [OPC_W-1:0] OPC_RLOAD = 6'h22;

   typedef enum logic [1:0] {
      KD_SINGLE = 2'd0,
      KD_END    = 2'd1,
      KD_LOAD   = 2'd2,
      KD_SKIP   = 2'd3
   } cmd_kind_e;

   typedef enum logic [1:0] {
      ST_HDR  = 2'd0,
      ST_SKIP = 2'd1,
      ST_LOAD = 2'd2,
      ST_HALT = 2'd3
   } seq_state_e;
endpackage

// File: rtl/cmdq_hdr_classify.sv
module cmdq_hdr_classify
   import cmdq_pkg::*;
#(
   parameter int MI_LEN_W       = 8,
   parameter int OTHER_LEN_W    = 8,
   parameter bit OTHER_HAS_LEN  = 1'b1,
   parameter int SHORT_OP_LIMIT = 16,
   parameter int MAX_PAIRS      = 126,
   parameter int CNT_W          = 9
) (
   input  logic [CMD_W-1:0] hdr,
   output cmd_kind_e        kind,
   output logic [CNT_W-1:0] payload,
   output logic             bad_load,
   output logic [2:0]       client,
   output logic             space_flag
);
   localparam int MAX_LEN = 2 * MAX_PAIRS - 1;

   logic [OPC_W-1:0]    opc;
   logic [MI_LEN_W-1:0] mi_len;
   logic [CNT_W-1:0]    mi_payload;
   cmd_kind_e           other_kind;
   logic [CNT_W-1:0]    other_payload;

   assign client     = hdr[CMD_W-1:CLIENT_LO];
   assign opc        = hdr[OPC_LO +: OPC_W];
   assign mi_len     = hdr[MI_LEN_W-1:0];
   assign mi_payload = CNT_W'(mi_len) + CNT_W'(1);
   assign space_flag = (client == CLI_MEMIF) && hdr[SPACE_BIT];

   generate
      if (OTHER_HAS_LEN) begin : g_other_len
         logic [OTHER_LEN_W-1:0] o_len;
         assign o_len         = hdr[OTHER_LEN_W-1:0];
         assign other_kind    = KD_SKIP;
         assign other_payload = CNT_W'(o_len) + CNT_W'(1);
      end else begin : g_other_single
         assign other_kind    = KD_SINGLE;
         assign other_payload = '0;
      end
   endgenerate

   always_comb begin
      kind     = KD_SINGLE;
      payload  = '0;
      bad_load = 1'b0;
      if (client != CLI_MEMIF) begin
         kind    = other_kind;
         payload = other_payload;
      end else if (opc == OPC_STOP) begin
         kind = KD_END;
      end else if (32'(opc) < SHORT_OP_LIMIT) begin
         kind = KD_SINGLE;
      end else if (opc == OPC_RLOAD) begin
         payload = mi_payload;
         if (!mi_len[0] || (32'(mi_len) > MAX_LEN)) begin
            kind     = KD_SKIP;
            bad_load = 1'b1;
         end else begin
            kind = KD_LOAD;
         end
      end else begin
         kind    = KD_SKIP;
         payload = mi_payload;
      end
   end
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
   import cmdq_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             restart,
   input  cmd_kind_e        kind,
   input  logic [CNT_W-1:0] payload,
   output logic             in_ready,
   output logic             hdr_take,
   output logic             addr_take,
   output logic             data_take
);
   seq_state_e       state;
   logic [CNT_W-1:0] rem;
   logic             phase;
   logic             take;

   assign in_ready  = (state != ST_HALT);
   assign take      = in_valid && in_ready;
   assign hdr_take  = take && (state == ST_HDR);
   assign addr_take = take && (state == ST_LOAD) && !phase;
   assign data_take = take && (state == ST_LOAD) && phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_HDR;
         rem   <= '0;
         phase <= 1'b0;
      end else begin
         case (state)
            ST_HDR: begin
               if (in_valid) begin
                  case (kind)
                     KD_END:  state <= ST_HALT;
                     KD_LOAD: begin
                        state <= ST_LOAD;
                        rem   <= payload;
                        phase <= 1'b0;
                     end
                     KD_SKIP: begin
                        state <= ST_SKIP;
                        rem   <= payload;
                     end
                     default: state <= ST_HDR;
                  endcase
               end
            end
            ST_SKIP, ST_LOAD: begin
               if (in_valid) begin
                  rem   <= rem - CNT_W'(1);
                  phase <= ~phase;
                  if (rem == CNT_W'(1)) state <= ST_HDR;
               end
            end
            default: begin
               if (restart) state <= ST_HDR;
            end
         endcase
      end
   end

   // R3
   rem_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP || state == ST_LOAD) |-> (rem != '0));

   // R8
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && !restart) |=> !in_ready);

   // R5
   pair_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOAD && rem == CNT_W'(1) && in_valid) |-> data_take);

   // R9
   restart_noeff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && restart && !hdr_take) |=> in_ready);
endmodule

// File: rtl/cmdq_wr_stage.sv
module cmdq_wr_stage
   import cmdq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_start,
   input  logic             space_in,
   input  logic             addr_take,
   input  logic             data_take,
   input  logic [CMD_W-1:0] din,
   output logic             wr_valid,
   output logic [CMD_W-1:0] wr_addr,
   output logic [CMD_W-1:0] wr_data,
   output logic             wr_global
);
   logic [CMD_W-1:0] addr_hold;
   logic             space_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_hold  <= '0;
         space_hold <= 1'b0;
         wr_valid   <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
         wr_global  <= 1'b0;
      end else begin
         wr_valid <= data_take;
         if (load_start) space_hold <= space_in;
         if (addr_take)  addr_hold  <= {din[CMD_W-1:2], 2'b00};
         if (data_take) begin
            wr_addr   <= addr_hold;
            wr_data   <= din;
            wr_global <= space_hold;
         end
      end
   end

   // R5
   wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
   import cmdq_pkg::*;
#(
   parameter int MI_LEN_W       = 8,
   parameter int OTHER_LEN_W    = 8,
   parameter bit OTHER_HAS_LEN  = 1'b1,
   parameter int SHORT_OP_LIMIT = 16,
   parameter int MAX_PAIRS      = 126
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   output logic        in_ready,
   input  logic [31:0] in_data,
   input  logic        restart,
   output logic        hdr_valid,
   output logic [2:0]  hdr_client,
   output logic        hdr_global,
   output logic        wr_valid,
   output logic [31:0] wr_addr,
   output logic [31:0] wr_data,
   output logic        wr_global,
   output logic        load_err
);
   localparam int LEN_W = (MI_LEN_W > OTHER_LEN_W) ? MI_LEN_W : OTHER_LEN_W;
   localparam int CNT_W = LEN_W + 1;

   generate
      if ((2 * MAX_PAIRS - 1) >= (1 << MI_LEN_W)) begin : g_bad_pairs
         $error("MAX_PAIRS does not fit the length field");
      end
      if (MI_LEN_W < 1 || MI_LEN_W > OPC_LO - 1 || OTHER_LEN_W < 1 || OTHER_LEN_W > 28) begin : g_bad_len
         $error("length field width out of range");
      end
      if (SHORT_OP_LIMIT > 34) begin : g_bad_short
         $error("SHORT_OP_LIMIT would swallow the register-load opcode");
      end
   endgenerate

   cmd_kind_e        kind;
   logic [CNT_W-1:0] payload;
   logic             bad_load;
   logic [2:0]       client;
   logic             space_flag;
   logic             hdr_take;
   logic             addr_take;
   logic             data_take;

   cmdq_hdr_classify #(
      .MI_LEN_W      (MI_LEN_W),
      .OTHER_LEN_W   (OTHER_LEN_W),
      .OTHER_HAS_LEN (OTHER_HAS_LEN),
      .SHORT_OP_LIMIT(SHORT_OP_LIMIT),
      .MAX_PAIRS     (MAX_PAIRS),
      .CNT_W         (CNT_W)
   ) u_cls (
      .hdr       (in_data),
      .kind      (kind),
      .payload   (payload),
      .bad_load  (bad_load),
      .client    (client),
      .space_flag(space_flag)
   );

   cmdq_seq #(.CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .restart  (restart),
      .kind     (kind),
      .payload  (payload),
      .in_ready (in_ready),
      .hdr_take (hdr_take),
      .addr_take(addr_take),
      .data_take(data_take)
   );

   cmdq_wr_stage u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_start(hdr_take && (kind == KD_LOAD)),
      .space_in  (space_flag),
      .addr_take (addr_take),
      .data_take (data_take),
      .din       (in_data),
      .wr_valid  (wr_valid),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_global (wr_global)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_valid  <= 1'b0;
         hdr_client <= '0;
         hdr_global <= 1'b0;
         load_err   <= 1'b0;
      end else begin
         hdr_valid <= hdr_take;
         if (hdr_take) begin
            hdr_client <= client;
            hdr_global <= space_flag;
            if (bad_load) load_err <= 1'b1;
         end
      end
   end

   // R8
   end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_take && kind == KD_END) |=> !in_ready);

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |=> load_err);

   // R1
   hdr_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_valid && wr_valid));

   // R1
   hdr_client_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && hdr_client != CLI_MEMIF) |-> !hdr_global);
endmodule

// File: tb/tb_cmd_stream_decoder.sv
`timescale 1ns/1ps
module tb_cmd_stream_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        restart = 1'b0;
   logic        in_ready, hdr_valid, hdr_global, wr_valid, wr_global, load_err;
   logic [2:0]  hdr_client;
   logic [31:0] wr_addr, wr_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int wr_seen = 0;
   int wr_exp_total = 0;
   string cur_req = "R10";

   always #4 clk = ~clk;

   cmd_stream_decoder dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .restart(restart), .hdr_valid(hdr_valid),
      .hdr_client(hdr_client), .hdr_global(hdr_global), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_global(wr_global),
      .load_err(load_err)
   );

   // behavioural reference: 0 header, 1 skipping, 2 loading, 3 stopped
   int          m_mode = 0;
   int          m_rem = 0;
   int          m_phase = 0;
   logic [31:0] m_addr = '0;
   logic        m_glob = 1'b0;
   logic        e_hv = 0, e_hg = 0, e_wv = 0, e_wg = 0, e_err = 0;
   logic [2:0]  e_hc = '0;
   logic [31:0] e_wa = '0, e_wd = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_rem = 0; m_phase = 0;
         e_hv = 0; e_wv = 0; e_err = 0;
      end else begin
         e_hv = 0; e_wv = 0;
         if (m_mode == 3) begin
            if (restart) m_mode = 0;
         end else if (in_valid) begin
            if (m_mode == 0) begin
               int op, ln;
               e_hv = 1;
               e_hc = in_data[31:29];
               e_hg = (in_data[31:29] == 3'd0) && in_data[22];
               op = int'(in_data[28:23]);
               ln = int'(in_data[7:0]);
               if (in_data[31:29] != 3'd0) begin
                  m_mode = 1; m_rem = ln + 1;
               end else if (op == 'h0A) begin
                  m_mode = 3;
               end else if (op < 16) begin
                  m_mode = 0;
               end else if (op == 'h22) begin
                  m_rem = ln + 1;
                  if ((ln % 2 == 1) && ln <= 251) begin
                     m_mode = 2; m_phase = 0; m_glob = in_data[22];
                  end else begin
                     m_mode = 1; e_err = 1;
                  end
               end else begin
                  m_mode = 1; m_rem = ln + 1;
               end
            end else begin
               if (m_mode == 2) begin
                  if (m_phase == 0) m_addr = in_data;
                  else begin
                     e_wv = 1;
                     e_wa = {m_addr[31:2], 2'b00};
                     e_wd = in_data;
                     e_wg = m_glob;
                     wr_exp_total++;
                  end
                  m_phase = 1 - m_phase;
               end
               m_rem--;
               if (m_rem == 0) m_mode = 0;
            end
         end
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (wr_valid === 1'b1) wr_seen++;
      chk("in_ready (R8)", 32'(in_ready), 32'(m_mode != 3));
      chk("hdr_valid (R1)", 32'(hdr_valid), 32'(e_hv));
      chk("wr_valid (R5)", 32'(wr_valid), 32'(e_wv));
      chk("load_err (R7)", 32'(load_err), 32'(e_err));
      if (e_hv) begin
         chk("hdr_client (R1)", 32'(hdr_client), 32'(e_hc));
         chk("hdr_global (R1)", 32'(hdr_global), 32'(e_hg));
      end
      if (e_wv) begin
         chk("wr_addr (R5)", wr_addr, e_wa);
         chk("wr_data (R5)", wr_data, e_wd);
         chk("wr_global (R6)", 32'(wr_global), 32'(e_wg));
      end
   end

   function automatic logic [31:0] mi(input logic [5:0] op, input logic g, input logic [7:0] len);
      return {3'd0, op, g, 14'd0, len};
   endfunction

   task automatic send(input logic [31:0] d);
      bit acc;
      in_valid = 1'b1;
      in_data  = d;
      do begin
         acc = in_ready;
         @(negedge clk);
      end while (!acc);
      in_valid = 1'b0;
   endtask

   task automatic gap();
      in_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset values
      chk("reset in_ready (R10)", 32'(in_ready), 32'd1);
      chk("reset wr_valid (R10)", 32'(wr_valid), 32'd0);
      chk("reset hdr_valid (R10)", 32'(hdr_valid), 32'd0);
      chk("reset load_err (R10)", 32'(load_err), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      cur_req = "R2";
      send(mi(6'h00, 1'b0, 8'h00));
      send(mi(6'h05, 1'b1, 8'h07));
      gap();
      send(mi(6'h00, 1'b0, 8'h00));

      cur_req = "R5";
      send(mi(6'h22, 1'b1, 8'd1));
      send(32'h0000_2037);
      send(32'hCAFE_0001);
      gap();
      cur_req = "R6";
      send(mi(6'h22, 1'b0, 8'd5));
      for (int i = 0; i < 3; i++) begin
         send(32'h1000_0101 + 32'(i * 16));
         if (i == 1) gap();
         send(32'hA5A5_0000 ^ 32'(i));
      end

      cur_req = "R3";
      send(mi(6'h26, 1'b1, 8'd1));
      send(mi(6'h22, 1'b0, 8'd1));
      send(mi(6'h0A, 1'b0, 8'd0));
      send(mi(6'h30, 1'b0, 8'd0));
      send(32'h0000_0044);

      cur_req = "R4";
      send({3'd2, 21'd0, 8'd4});
      for (int i = 0; i < 5; i++) send(mi(6'h0A, 1'b1, 8'd0));
      send({3'd3, 1'b0, 1'b1, 19'd0, 8'd0});
      send(mi(6'h22, 1'b1, 8'd1));

      cur_req = "R7";
      send(mi(6'h22, 1'b0, 8'd2));
      for (int i = 0; i < 3; i++) send(32'h0000_0100 + 32'(i));
      send(mi(6'h22, 1'b1, 8'd253));
      for (int i = 0; i < 254; i++) send(32'(i) << 4);
      send(mi(6'h00, 1'b0, 8'd0));

      cur_req = "R9";
      send(mi(6'h22, 1'b1, 8'd3));
      send(32'h0000_0203);
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      send(32'h1111_2222);
      send(32'h0000_0300);
      send(32'h3333_4444);

      cur_req = "R8";
      send(mi(6'h0A, 1'b0, 8'd0));
      in_valid = 1'b1;
      in_data  = mi(6'h22, 1'b1, 8'd1);
      repeat (4) @(negedge clk);
      chk("stopped in_ready (R8)", 32'(in_ready), 32'd0);
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      in_valid = 1'b0;
      chk("resumed in_ready (R8)", 32'(in_ready), 32'd1);
      send({3'd2, 21'd0, 8'd0});
      send(32'hFFFF_FFFF);

      cur_req = "R5";
      send(mi(6'h22, 1'b0, 8'd251));
      for (int i = 0; i < 126; i++) begin
         send(32'h4000_0000 + 32'(i * 4 + (i % 4)));
         send(32'h7700_0000 + 32'(i));
      end
      send(mi(6'h00, 1'b0, 8'd0));
      repeat (3) @(negedge clk);

      chk("write count (R5)", 32'(wr_seen), 32'(wr_exp_total));
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 100000);
      errors++;
      $display("FAIL watchdog %s: actual %0d cycles expected completion", cur_req, cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule